// File: doc/BRIEF.md
# DMA Flyby Cycle Generator

This block sits between a DMA channel sequencer and an external memory controller. It issues single-address transfers, in which data moves straight between memory and an external I/O device over the memory-side data bus. The data never passes through an internal register. The sequencer presents a request that carries a channel number and a direction. If the memory controller signals that it can run such cycles, the block grants the request. It then runs one bus cycle that drives:

- the channel's stored memory address,
- a dedicated cycle-type code,
- a crossed pair of active-low strobes, one on the memory side and one on the I/O side,
- the active-low select line of that channel, which picks the I/O device.

Each channel holds a memory address and a transfer count, both loaded through a small configuration port. Every completed cycle decrements the serviced channel's count. A terminal-count flag shows when a count has run out. The memory controller can lengthen a cycle by holding its ready input low. A request is refused, with a one-clock error pulse, if flyby cycles are disabled or if the requested channel's count is already zero.

Top module: `flyby_cycle_gen`

## Requirements
- R1: When idle, a request with `flyby_en` high on a channel whose count is nonzero raises `req_grant` in the same cycle. The bus cycle begins on the next clock, with the strobes active from that clock onward.
- R2: During a cycle, `bus_addr` equals the memory address last loaded for the granted channel, whatever the direction. It is held unchanged until the cycle ends.
- R3: With `req_dir` = 0 (memory to I/O), `mem_rd_n` and `io_wr_n` are low together, and `mem_wr_n` and `io_rd_n` stay high.
- R4: With `req_dir` = 1 (I/O to memory), `mem_wr_n` and `io_rd_n` are low together, and `mem_rd_n` and `io_wr_n` stay high.
- R5: `bus_type` is 3'b111 throughout a cycle and 3'b000 at all other times.
- R6: During a cycle, only bit n of `ch_act_n` is low, where n is the granted channel. Outside a cycle all bits are high.
- R7: `int_dout` stays at zero at all times; no data passes through the block.
- R8: The strobes, address and select line stay asserted as long as `mem_ready` is sampled low. On the clock at which `mem_ready` is sampled high, the cycle ends. `done` is then high for exactly one clock, and the strobes return high.
- R9: A request made while `flyby_en` is low is not granted and starts no cycle. `err` is high for one clock after the refusing edge.
- R10: Each completed cycle lowers the channel's count by one. `tc[n]` is high exactly when channel n's count is zero, and a request to such a channel is refused with `err` as in R9.
- R11: After reset, all strobes and `ch_act_n` bits are high, `bus_type` is 3'b000, `done` and `err` are low, and every count is zero, so all `tc` bits are high.
- R12: A configuration write loads a channel's address and count on the next clock, so `tc` for that channel then shows whether the count is zero. A write takes precedence over a decrement in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flyby_en | input | 1 | Memory controller can run flyby cycles |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel being configured |
| cfg_addr | input | 26 | Memory address to load |
| cfg_cnt | input | 16 | Transfer count to load |
| req_valid | input | 1 | Transfer request from sequencer |
| req_ch | input | 2 | Requested channel |
| req_dir | input | 1 | 0 = memory to I/O, 1 = I/O to memory |
| req_grant | output | 1 | Request accepted this cycle |
| done | output | 1 | One-clock pulse when a cycle completes |
| err | output | 1 | One-clock pulse when a request is refused |
| mem_ready | input | 1 | Memory controller ends the current cycle |
| bus_addr | output | 26 | Memory-side address |
| bus_type | output | 3 | Bus cycle-type code |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| ch_act_n | output | 4 | Per-channel I/O select, active low |
| tc | output | 4 | Per-channel terminal-count flags |
| int_dout | output | 32 | Internal data-out bus, held idle |

## Verification
`req_grant` is combinational, so the bench reads it in the same cycle as the request. Strobes, address, type and select change one clock after the accepting edge. `done`, the strobe release and the updated `tc` appear one clock after the edge that samples `mem_ready` high. `err` appears one clock after a refusing edge, and a configuration write shows in `tc` one clock later. The bench drives inputs on the falling edge and samples 1 ns after it, so each check reads the state left by exactly the preceding rising edge. It also checks that `done` and `err` drop again one clock later.

// File: rtl/flyby_pkg.sv
package flyby_pkg;

   typedef enum logic {
      DIR_MEM2IO = 1'b0,
      DIR_IO2MEM = 1'b1
   } fb_dir_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } fb_state_e;

   typedef struct packed {
      logic mem_rd_n;
      logic mem_wr_n;
      logic io_rd_n;
      logic io_wr_n;
   } fb_strobe_t;

   localparam fb_strobe_t STROBE_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                          io_rd_n: 1'b1, io_wr_n: 1'b1};

   // Crossed strobe pair chosen by direction
   function automatic fb_strobe_t strobe_for(input fb_dir_e dir);
      fb_strobe_t s;
      s = STROBE_IDLE;
      if (dir == DIR_MEM2IO) begin
         s.mem_rd_n = 1'b0;
         s.io_wr_n  = 1'b0;
      end else begin
         s.mem_wr_n = 1'b0;
         s.io_rd_n  = 1'b0;
      end
      return s;
   endfunction

endpackage

// File: rtl/flyby_chan_bank.sv
module flyby_chan_bank #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 26,
   parameter int CNT_W  = 16,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic              dec_en,
   input  logic [CH_W-1:0]   dec_ch,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [NUM_CH-1:0] tc
);

   logic [ADDR_W-1:0] addr_q [NUM_CH];
   logic [CNT_W-1:0]  cnt_q  [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[g] <= '0;
            cnt_q[g]  <= '0;
         end else if (cfg_we && (cfg_ch == CH_W'(g))) begin
            addr_q[g] <= cfg_addr;
            cnt_q[g]  <= cfg_cnt;
         end else if (dec_en && (dec_ch == CH_W'(g)) && (cnt_q[g] != '0)) begin
            cnt_q[g]  <= cnt_q[g] - CNT_W'(1);
         end
      end

      assign tc[g] = (cnt_q[g] == '0);
   end

   assign rd_addr = addr_q[rd_ch];

endmodule

// File: rtl/flyby_seq.sv
module flyby_seq
   import flyby_pkg::*;
#(
   parameter int          NUM_CH     = 4,
   parameter int          ADDR_W     = 26,
   parameter int          TYPE_W     = 3,
   parameter logic [TYPE_W-1:0] FLYBY_TYPE = 3'b111,
   parameter logic [TYPE_W-1:0] IDLE_TYPE  = 3'b000,
   localparam int         CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CH_W-1:0]   req_ch,
   input  fb_dir_e           req_dir,
   input  logic              flyby_en,
   input  logic              req_tc,
   input  logic [ADDR_W-1:0] ch_addr,
   input  logic              mem_ready,
   output logic              req_grant,
   output logic              done,
   output logic              err,
   output logic              dec_en,
   output logic [CH_W-1:0]   dec_ch,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [TYPE_W-1:0] bus_type,
   output fb_strobe_t        strobes,
   output logic [NUM_CH-1:0] ch_act_n
);

   fb_state_e   state_q;
   logic        accept, reject, finish;
   logic [CH_W-1:0] cur_ch_q;

   always_comb begin
      accept = (state_q == ST_IDLE) && req_valid && flyby_en && !req_tc;
      reject = (state_q == ST_IDLE) && req_valid && !accept;
      finish = (state_q == ST_XFER) && mem_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         strobes  <= STROBE_IDLE;
         bus_type <= IDLE_TYPE;
         bus_addr <= '0;
         ch_act_n <= '1;
         cur_ch_q <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         done <= finish;
         err  <= reject;
         if (accept) begin
            state_q  <= ST_XFER;
            strobes  <= strobe_for(req_dir);
            bus_type <= FLYBY_TYPE;
            bus_addr <= ch_addr;
            ch_act_n <= ~(NUM_CH'(1) << req_ch);
            cur_ch_q <= req_ch;
         end else if (finish) begin
            state_q  <= ST_IDLE;
            strobes  <= STROBE_IDLE;
            bus_type <= IDLE_TYPE;
            ch_act_n <= '1;
         end
      end
   end

   assign req_grant = accept;
   assign dec_en    = finish;
   assign dec_ch    = cur_ch_q;

endmodule

// File: rtl/flyby_cycle_gen.sv
module flyby_cycle_gen
   import flyby_pkg::*;
#(
   parameter int          NUM_CH     = 4,
   parameter int          ADDR_W     = 26,
   parameter int          CNT_W      = 16,
   parameter int          DATA_W     = 32,
   parameter int          TYPE_W     = 3,
   parameter logic [TYPE_W-1:0] FLYBY_TYPE = 3'b111,
   parameter logic [TYPE_W-1:0] IDLE_TYPE  = 3'b000,
   localparam int         CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flyby_en,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic              req_valid,
   input  logic [CH_W-1:0]   req_ch,
   input  logic              req_dir,
   output logic              req_grant,
   output logic              done,
   output logic              err,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [TYPE_W-1:0] bus_type,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              io_rd_n,
   output logic              io_wr_n,
   output logic [NUM_CH-1:0] ch_act_n,
   output logic [NUM_CH-1:0] tc,
   output logic [DATA_W-1:0] int_dout
);

   // Elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_num_ch
      $error("flyby_cycle_gen: NUM_CH out of range");
   end
   if (ADDR_W < 1 || CNT_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("flyby_cycle_gen: widths must be positive");
   end
   if (FLYBY_TYPE == IDLE_TYPE) begin : g_bad_type
      $error("flyby_cycle_gen: flyby and idle type codes must differ");
   end

   logic              dec_en;
   logic [CH_W-1:0]   dec_ch;
   logic [ADDR_W-1:0] sel_addr;
   fb_strobe_t        strobes;

   flyby_chan_bank #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_ch   (cfg_ch),
      .cfg_addr (cfg_addr),
      .cfg_cnt  (cfg_cnt),
      .dec_en   (dec_en),
      .dec_ch   (dec_ch),
      .rd_ch    (req_ch),
      .rd_addr  (sel_addr),
      .tc       (tc)
   );

   flyby_seq #(
      .NUM_CH     (NUM_CH),
      .ADDR_W     (ADDR_W),
      .TYPE_W     (TYPE_W),
      .FLYBY_TYPE (FLYBY_TYPE),
      .IDLE_TYPE  (IDLE_TYPE)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ch    (req_ch),
      .req_dir   (fb_dir_e'(req_dir)),
      .flyby_en  (flyby_en),
      .req_tc    (tc[req_ch]),
      .ch_addr   (sel_addr),
      .mem_ready (mem_ready),
      .req_grant (req_grant),
      .done      (done),
      .err       (err),
      .dec_en    (dec_en),
      .dec_ch    (dec_ch),
      .bus_addr  (bus_addr),
      .bus_type  (bus_type),
      .strobes   (strobes),
      .ch_act_n  (ch_act_n)
   );

   assign mem_rd_n = strobes.mem_rd_n;
   assign mem_wr_n = strobes.mem_wr_n;
   assign io_rd_n  = strobes.io_rd_n;
   assign io_wr_n  = strobes.io_wr_n;

   // Data moves on the memory-side bus only
   assign int_dout = '0;

endmodule

// File: rtl/flyby_cycle_chk.sv
module flyby_cycle_chk #(
   parameter int          NUM_CH     = 4,
   parameter int          ADDR_W     = 26,
   parameter int          TYPE_W     = 3,
   parameter logic [TYPE_W-1:0] FLYBY_TYPE = 3'b111
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flyby_en,
   input logic              req_grant,
   input logic              done,
   input logic              err,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [TYPE_W-1:0] bus_type,
   input logic              mem_rd_n,
   input logic              mem_wr_n,
   input logic              io_rd_n,
   input logic              io_wr_n,
   input logic [NUM_CH-1:0] ch_act_n
);

   logic active;
   assign active = !mem_rd_n || !mem_wr_n;

   assert_strobe_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_n == io_wr_n) && (mem_wr_n == io_rd_n) && (mem_rd_n || mem_wr_n));

   assert_cycle_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active == (bus_type == FLYBY_TYPE));

   assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ch_act_n) && (active == (ch_act_n != '1)));

   assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mem_ready) |=> (active && $stable(bus_addr) && $stable(ch_act_n)));

   assert_cycle_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mem_ready) |=> (!active && done));

   assert_grant_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |-> flyby_en);

   assert_grant_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |=> active);

   assert_err_no_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!done && !active));

endmodule

bind flyby_cycle_gen flyby_cycle_chk #(
   .NUM_CH     (NUM_CH),
   .ADDR_W     (ADDR_W),
   .TYPE_W     (TYPE_W),
   .FLYBY_TYPE (FLYBY_TYPE)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flyby_en  (flyby_en),
   .req_grant (req_grant),
   .done      (done),
   .err       (err),
   .mem_ready (mem_ready),
   .bus_addr  (bus_addr),
   .bus_type  (bus_type),
   .mem_rd_n  (mem_rd_n),
   .mem_wr_n  (mem_wr_n),
   .io_rd_n   (io_rd_n),
   .io_wr_n   (io_wr_n),
   .ch_act_n  (ch_act_n)
);

// File: tb/test_flyby_cycle_gen.sv
`timescale 1ns/1ps
module test_flyby_cycle_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flyby_en = 1'b1;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_ch = '0;
   logic [25:0] cfg_addr = '0;
   logic [15:0] cfg_cnt = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_ch = '0;
   logic        req_dir = 1'b0;
   logic        mem_ready = 1'b0;
   logic        req_grant, done, err;
   logic [25:0] bus_addr;
   logic [2:0]  bus_type;
   logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
   logic [3:0]  ch_act_n, tc;
   logic [31:0] int_dout;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [25:0] exp_addr [4];
   int          exp_cnt  [4];

   always #2 clk = ~clk;

   flyby_cycle_gen i_flyby_cycle_gen (
      .clk(clk), .rst_n(rst_n), .flyby_en(flyby_en),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt),
      .req_valid(req_valid), .req_ch(req_ch), .req_dir(req_dir),
      .req_grant(req_grant), .done(done), .err(err), .mem_ready(mem_ready),
      .bus_addr(bus_addr), .bus_type(bus_type),
      .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
      .ch_act_n(ch_act_n), .tc(tc), .int_dout(int_dout)
   );

   function automatic logic [3:0] exp_strobe(input bit dir);
      // packed as {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
      return dir ? 4'b1001 : 4'b0110;
   endfunction

   function automatic logic [3:0] exp_act(input int ch);
      return ~(4'b0001 << ch);
   endfunction

   function automatic logic [3:0] exp_tc();
      logic [3:0] t;
      for (int i = 0; i < 4; i++) t[i] = (exp_cnt[i] == 0);
      return t;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic load(input int ch, input logic [25:0] a, input int cnt);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_addr = a; cfg_cnt = 16'(cnt);
      @(negedge clk);
      cfg_we = 1'b0;
      exp_addr[ch] = a; exp_cnt[ch] = cnt;
      #1 chk(tc == exp_tc(), "R12 tc after load", 32'(tc), 32'(exp_tc()));
   endtask

   task automatic do_xfer(input int ch, input bit dir, input int wt);
      logic [3:0] s;
      @(negedge clk);
      req_valid = 1'b1; req_ch = 2'(ch); req_dir = dir; flyby_en = 1'b1;
      #1 chk(req_grant == 1'b1, "R1 grant", 32'(req_grant), 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i <= wt; i++) begin
         if (i > 0) @(negedge clk);
         mem_ready = (i == wt);
         #1;
         s = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
         chk(s == exp_strobe(dir), dir ? "R4 strobes" : "R3 strobes",
             32'(s), 32'(exp_strobe(dir)));
         chk(bus_addr == exp_addr[ch], "R2 address", 32'(bus_addr), 32'(exp_addr[ch]));
         chk(bus_type == 3'b111, "R5 type active", 32'(bus_type), 32'd7);
         chk(ch_act_n == exp_act(ch), "R6 select", 32'(ch_act_n), 32'(exp_act(ch)));
         chk(int_dout == '0, "R7 data idle", int_dout, 32'd0);
         chk(done == 1'b0, "R8 no early done", 32'(done), 32'd0);
      end
      @(negedge clk);
      mem_ready = 1'b0;
      exp_cnt[ch] = exp_cnt[ch] - 1;
      #1;
      s = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
      chk(done == 1'b1, "R8 done pulse", 32'(done), 32'd1);
      chk(s == 4'hF, "R8 strobes released", 32'(s), 32'hF);
      chk(bus_type == 3'b000 && ch_act_n == 4'hF, "R5 R6 idle",
          32'({bus_type, ch_act_n}), 32'h0F);
      chk(tc == exp_tc(), "R10 count", 32'(tc), 32'(exp_tc()));
      @(negedge clk);
      #1 chk(done == 1'b0, "R8 done one clock", 32'(done), 32'd0);
   endtask

   task automatic do_reject(input int ch, input bit dir, input bit en, input string req);
      logic [3:0] s;
      @(negedge clk);
      req_valid = 1'b1; req_ch = 2'(ch); req_dir = dir; flyby_en = en;
      #1 chk(req_grant == 1'b0, req, 32'(req_grant), 32'd0);
      @(negedge clk);
      req_valid = 1'b0; flyby_en = 1'b1;
      #1;
      s = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
      chk(err == 1'b1, req, 32'(err), 32'd1);
      chk(s == 4'hF && ch_act_n == 4'hF, req, 32'({s, ch_act_n}), 32'hFF);
      chk(tc == exp_tc(), req, 32'(tc), 32'(exp_tc()));
      @(negedge clk);
      #1 chk(err == 1'b0, req, 32'(err), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 50000; i++) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) begin exp_addr[i] = '0; exp_cnt[i] = 0; end
      repeat (3) @(negedge clk);
      #1;
      // R11 reset state
      chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R11 strobes",
          32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'hF);
      chk(bus_type == 3'b000 && ch_act_n == 4'hF, "R11 type/select",
          32'({bus_type, ch_act_n}), 32'h0F);
      chk(done == 1'b0 && err == 1'b0, "R11 pulses", 32'({done, err}), 32'd0);
      chk(tc == 4'hF, "R11 tc", 32'(tc), 32'hF);
      @(negedge clk);
      rst_n = 1'b1;

      // Directed corner cases
      do_reject(2, 1'b0, 1'b1, "R10 reject zero count");
      load(0, 26'h3FFFFFF, 1);
      load(1, 26'h0000001, 3);
      load(2, 26'h1234567, 2);
      load(3, 26'h2AAAAAA, 0);
      do_xfer(0, 1'b0, 0);                     // R3, last count -> tc
      do_reject(0, 1'b1, 1'b1, "R10 reject after tc");
      do_xfer(1, 1'b1, 3);                     // R4 with stretched cycle
      do_reject(1, 1'b0, 1'b0, "R9 reject disabled");
      do_reject(3, 1'b0, 1'b1, "R12 zero-count load");

      // Constrained random mix
      for (int it = 0; it < 60; it++) begin
         int ch, r;
         bit dir;
         ch  = int'($urandom % 4);
         dir = 1'($urandom % 2);
         r   = int'($urandom % 8);
         if (r == 0)
            do_reject(ch, dir, 1'b0, "R9 reject disabled");
            else if (r == 1)
            load(ch, 26'($urandom), int'($urandom % 4));
         else if (exp_cnt[ch] == 0)
            do_reject(ch, dir, 1'b1, "R10 reject zero count");
         else
            do_xfer(ch, dir, int'($urandom % 4));
      end

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule